// File: doc/BRIEF.md
# Looping Pattern Generator

This block plays back a stored sequence of digital words onto a bank of output pins. A host load port fills a pattern memory one word at a time and programs the pattern length. A small command interface then starts playback in single-shot or continuous mode, advances it word by word in step mode, halts it, or clears it. Memory words are `WORD_W` bits wide, and only the low `PIN_W` bits reach the pins. A sample-enable input marks each edge of the sample clock. Clock generation and pin switching sit outside the block.

The controller has four states. CLEAR zeroes the whole memory, one address per cycle, with `busy` high. READY is the stopped state: the pins are released and read zero. RUN plays one word per sample enable. STEP plays one word per step command. The transitions are:
- any state to CLEAR on reset or a clear command;
- CLEAR to READY once the last address has been written;
- READY to RUN on a start command;
- READY to STEP on a step command;
- RUN to READY on a stop command, or, in single-shot mode, on the sample enable after the last word;
- STEP to READY on a stop command.

The default depth is 1024 words (`ADDR_W` = 10). The full 64K-word depth uses `ADDR_W` = 16, and its clear then lasts 65536 cycles.

Top module: `pattern_streamer`

## Requirements
- R1: After reset is released, or one cycle after a clear command, `busy` stays high for exactly 2^ADDR_W clock cycles. Afterwards every memory word reads as zero and the length register is 0. Start and step commands are ignored while `busy` is high.
- R2: In CLEAR and READY, `pin_hiz` is 1 and `pin_data` is all zeros.
- R3: An emitted word drives `pin_data` with bits [PIN_W-1:0] of the stored word. The upper bits never reach the pins.
- R4: In RUN, the cycle after each sample enable shows the next word. Without a sample enable, `pin_data` holds its value. `pin_hiz` stays 1 until the first word has been emitted.
- R5: Single-shot mode (`cmd_cont`=0 when started) emits words 0 to L in order, where L is the length register. The next sample enable returns the block to READY.
- R6: Continuous mode (`cmd_cont`=1 when started) emits word 0 again after word L, and repeats without end.
- R7: A step command from READY emits word 0. Each later step emits the next word. Sample enables have no effect in STEP. Once word L is shown, further steps leave it unchanged.
- R8: The length register holds the word count minus one. A value of 0 plays a single word.
- R9: A stop command in RUN or STEP returns the block to READY on the next cycle. Start and step commands given while playing do not restart the pattern.
- R10: Word writes and length writes that arrive while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a memory clear |
| wr_en | input | 1 | Write `wr_data` into the pattern memory at `wr_addr` |
| wr_addr | input | ADDR_W | Pattern memory write address |
| wr_data | input | WORD_W | Pattern word to store |
| len_we | input | 1 | Load the length register from `len_in` |
| len_in | input | ADDR_W | Pattern length minus one |
| cmd_start | input | 1 | Start playback from READY |
| cmd_cont | input | 1 | Mode sampled with `cmd_start`: 1 continuous, 0 single-shot |
| cmd_step | input | 1 | Emit one word in step mode |
| cmd_stop | input | 1 | Return to READY |
| cmd_clear | input | 1 | Zero the memory and the length, then go to READY |
| sample_en | input | 1 | One-cycle marker for each sample clock edge |
| busy | output | 1 | High while the memory is being cleared |
| pin_data | output | PIN_W | Pattern word driven to the pins |
| pin_hiz | output | 1 | High when the pins are released |

## Verification
The bench builds the block with `ADDR_W` = 4, `WORD_W` = 32 and `PIN_W` = 20. The 16-word memory can then be cleared and counted through in full. Every address can be played after a clear to confirm that it reads zero. The bench also measures the exact length of `busy` after reset and after a clear command. Eight stored words with mixed upper bits show that only the low 20 bits reach the pins. Short lengths of 0, 2 and 3 place the single-shot end, the continuous wrap and the step end within a few cycles of one another.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
    typedef enum logic [1:0] {
        ST_CLEAR,
        ST_READY,
        ST_RUN,
        ST_STEP
    } pg_state_t;
endpackage

// File: rtl/pgen_mem.sv
module pgen_mem #(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/pgen_clear.sv
module pgen_clear #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [ADDR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign addr = cnt_q;
    assign last = &cnt_q;
endmodule

// File: rtl/pgen_ctrl.sv
module pgen_ctrl
    import pgen_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PIN_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_cont,
    input  logic              cmd_step,
    input  logic              cmd_stop,
    input  logic              cmd_clear,
    input  logic              sample_en,
    input  logic              clr_last,
    input  logic [ADDR_W-1:0] len,
    input  logic [PIN_W-1:0]  rd_word,
    output pg_state_t         state,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PIN_W-1:0]  pin_data,
    output logic              pin_hiz
);
    pg_state_t         state_q, state_nx;
    logic              mode_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              last_q;
    logic              drive_q;
    logic [PIN_W-1:0]  word_q;
    logic              emit;
    logic              at_end;

    // next-state selection
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_CLEAR: if (clr_last)                 state_nx = ST_READY;
            ST_READY: if (cmd_start)                state_nx = ST_RUN;
                      else if (cmd_step)            state_nx = ST_STEP;
            ST_RUN:   if (cmd_stop)                 state_nx = ST_READY;
                      else if (sample_en && last_q && !mode_q)
                                                    state_nx = ST_READY;
            ST_STEP:  if (cmd_stop)                 state_nx = ST_READY;
        endcase
        if (cmd_clear) state_nx = ST_CLEAR;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CLEAR;
        else        state_q <= state_nx;
    end

    assign rd_addr = (state_q == ST_READY) ? '0 : ptr_q;
    assign at_end  = (rd_addr == len);

    always_comb begin
        emit = 1'b0;
        unique case (state_q)
            ST_CLEAR: emit = 1'b0;
            ST_READY: emit = cmd_step && !cmd_start;
            ST_RUN:   emit = sample_en && !(last_q && !mode_q);
            ST_STEP:  emit = cmd_step && !last_q;
        endcase
        if (cmd_clear || cmd_stop) emit = 1'b0;
    end

    // output and pointer registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 1'b0;
            ptr_q   <= '0;
            last_q  <= 1'b0;
            drive_q <= 1'b0;
            word_q  <= '0;
        end else if (state_nx == ST_READY || state_nx == ST_CLEAR) begin
            ptr_q   <= '0;
            last_q  <= 1'b0;
            drive_q <= 1'b0;
            word_q  <= '0;
        end else if (emit) begin
            word_q  <= rd_word;
            drive_q <= 1'b1;
            last_q  <= at_end;
            ptr_q   <= at_end ? '0 : rd_addr + 1'b1;
        end else if (state_q == ST_READY && state_nx == ST_RUN) begin
            mode_q  <= cmd_cont;
            ptr_q   <= '0;
            last_q  <= 1'b0;
        end
    end

    assign state    = state_q;
    assign pin_data = word_q;
    assign pin_hiz  = ~drive_q;

    // R2
    stopped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY || state_q == ST_CLEAR) |-> (pin_hiz && pin_data == '0));

    // R4
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !sample_en && !cmd_stop && !cmd_clear) |=> $stable(pin_data));

    // R5
    single_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !mode_q && sample_en && last_q && !cmd_stop && !cmd_clear)
        |=> (state_q == ST_READY));

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && mode_q && sample_en && at_end && !cmd_stop && !cmd_clear)
        |=> (ptr_q == '0 && state_q == ST_RUN));

    // R7
    step_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && last_q && !cmd_stop && !cmd_clear) |=> $stable(pin_data));

    // R9
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN || state_q == ST_STEP) && cmd_stop && !cmd_clear)
        |=> (state_q == ST_READY));
endmodule

// File: rtl/pattern_streamer.sv
module pattern_streamer
    import pgen_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 32,
    parameter int PIN_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              len_we,
    input  logic [ADDR_W-1:0] len_in,
    input  logic              cmd_start,
    input  logic              cmd_cont,
    input  logic              cmd_step,
    input  logic              cmd_stop,
    input  logic              cmd_clear,
    input  logic              sample_en,
    output logic              busy,
    output logic [PIN_W-1:0]  pin_data,
    output logic              pin_hiz
);
    pg_state_t         state;
    logic              clearing;
    logic [ADDR_W-1:0] clr_addr;
    logic              clr_last;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;
    logic [ADDR_W-1:0] len_q;
    logic              unused_hi;

    assign clearing = (state == ST_CLEAR);
    assign busy     = clearing;

    // the clear sweep owns the write port while it runs
    assign mem_we    = clearing | wr_en;
    assign mem_waddr = clearing ? clr_addr : wr_addr;
    assign mem_wdata = clearing ? '0 : wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   len_q <= '0;
        else if (cmd_clear)           len_q <= '0;
        else if (len_we && !clearing) len_q <= len_in;
    end

    pgen_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    pgen_clear #(.ADDR_W(ADDR_W)) u_clear (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cmd_clear),
        .advance (clearing),
        .addr    (clr_addr),
        .last    (clr_last)
    );

    pgen_ctrl #(.ADDR_W(ADDR_W), .PIN_W(PIN_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_cont  (cmd_cont),
        .cmd_step  (cmd_step),
        .cmd_stop  (cmd_stop),
        .cmd_clear (cmd_clear),
        .sample_en (sample_en),
        .clr_last  (clr_last),
        .len       (len_q),
        .rd_word   (rd_word[PIN_W-1:0]),
        .state     (state),
        .rd_addr   (rd_addr),
        .pin_data  (pin_data),
        .pin_hiz   (pin_hiz)
    );

    assign unused_hi = ^rd_word[WORD_W-1:PIN_W];

    // R1
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_clear) |=> (pin_hiz && !(busy && $past(clr_last)) ));

    // R10
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mem_we && mem_wdata == '0));

    // R10
    clear_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_clear) |=> $stable(len_q));
endmodule

// File: tb/pattern_streamer_test.sv
module pattern_streamer_test;
    localparam int AW = 4;
    localparam int WW = 32;
    localparam int PW = 20;
    localparam int DEPTH = 1 << AW;

    localparam logic [WW-1:0] LOAD_TAB [8] = '{
        32'hA5A5_A5A5, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
        32'hFFF0_0000, 32'h000F_FFFF, 32'h8765_4321, 32'h0ABC_DEF0
    };
    localparam logic [PW-1:0] EXP_TAB [8] = '{
        20'h5A5A5, 20'h00000, 20'hFFFFF, 20'h45678,
        20'h00000, 20'hFFFFF, 20'h54321, 20'hCDEF0
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [WW-1:0] wr_data = '0;
    logic          len_we = 1'b0;
    logic [AW-1:0] len_in = '0;
    logic          cmd_start = 1'b0, cmd_cont = 1'b0, cmd_step = 1'b0;
    logic          cmd_stop = 1'b0, cmd_clear = 1'b0, sample_en = 1'b0;
    logic          busy, pin_hiz;
    logic [PW-1:0] pin_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pattern_streamer #(.ADDR_W(AW), .WORD_W(WW), .PIN_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .len_we(len_we), .len_in(len_in), .cmd_start(cmd_start), .cmd_cont(cmd_cont),
        .cmd_step(cmd_step), .cmd_stop(cmd_stop), .cmd_clear(cmd_clear),
        .sample_en(sample_en), .busy(busy), .pin_data(pin_data), .pin_hiz(pin_hiz)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_len(input logic [AW-1:0] v);
        len_we = 1'b1; len_in = v; cyc(); len_we = 1'b0;
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (busy && n < 4 * DEPTH) begin
            cyc(); n++;
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R1 busy after reset", busy, 1);
        chk("R2 hiz after reset", pin_hiz, 1);
        chk("R2 data after reset", pin_data, 0);
        cmd_start = 1'b1;                        // R1: ignored while busy
        wait_busy(n);
        cmd_start = 1'b0;
        chk("R1 reset clear length", n, DEPTH);
        chk("R1 start ignored while busy", pin_hiz, 1);
        cyc();
        chk("R1 start ignored while busy, still stopped", pin_hiz, 1);

        // load table
        for (int i = 0; i < 8; i++) begin
            wr_en = 1'b1; wr_addr = AW'(i); wr_data = LOAD_TAB[i]; cyc();
        end
        wr_en = 1'b0;

        // table walk: single-shot over all eight words (R3 R4 R5)
        set_len(4'd7);
        cmd_start = 1'b1; cmd_cont = 1'b0; cyc(); cmd_start = 1'b0;
        chk("R4 hiz before first sample", pin_hiz, 1);
        sample_en = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cyc();
            chk("R3 R5 word", pin_data, EXP_TAB[i]);
            chk("R4 driven", pin_hiz, 0);
        end
        cyc();
        sample_en = 1'b0;
        chk("R5 end hiz", pin_hiz, 1);
        chk("R5 end data", pin_data, 0);
        sample_en = 1'b1; cyc(); sample_en = 1'b0;
        chk("R5 stays stopped", pin_hiz, 1);

        // continuous, L=2 (R6, R4 hold, R9)
        set_len(4'd2);
        cmd_start = 1'b1; cmd_cont = 1'b1; cyc(); cmd_start = 1'b0; cmd_cont = 1'b0;
        sample_en = 1'b1;
        for (int i = 0; i < 7; i++) begin
            cyc();
            chk("R6 wrap sequence", pin_data, EXP_TAB[i % 3]);
        end
        sample_en = 1'b0;
        repeat (3) cyc();
        chk("R4 hold without sample", pin_data, EXP_TAB[0]);
        cmd_start = 1'b1; cyc(); cmd_start = 1'b0;
        chk("R9 start while running ignored", pin_data, EXP_TAB[0]);
        sample_en = 1'b1; cyc(); sample_en = 1'b0;
        chk("R9 no restart", pin_data, EXP_TAB[1]);
        cmd_stop = 1'b1; cyc(); cmd_stop = 1'b0;
        chk("R9 stop hiz", pin_hiz, 1);
        chk("R9 stop data", pin_data, 0);

        // step, L=3 (R7)
        set_len(4'd3);
        cmd_step = 1'b1; cyc(); cmd_step = 1'b0;
        chk("R7 first step", pin_data, EXP_TAB[0]);
        chk("R7 first step driven", pin_hiz, 0);
        sample_en = 1'b1; repeat (3) cyc(); sample_en = 1'b0;
        chk("R7 sample ignored", pin_data, EXP_TAB[0]);
        for (int i = 1; i < 4; i++) begin
            cmd_step = 1'b1; cyc(); cmd_step = 1'b0;
            chk("R7 step word", pin_data, EXP_TAB[i]);
        end
        cmd_step = 1'b1; cyc(); cyc(); cmd_step = 1'b0;
        chk("R7 no wrap", pin_data, EXP_TAB[3]);
        cmd_stop = 1'b1; cyc(); cmd_stop = 1'b0;
        chk("R9 stop from step", pin_hiz, 1);

        // length 0 (R8)
        set_len(4'd0);
        cmd_start = 1'b1; cyc(); cmd_start = 1'b0;
        sample_en = 1'b1; cyc();
        chk("R8 single word", pin_data, EXP_TAB[0]);
        cyc(); sample_en = 1'b0;
        chk("R8 ends after one", pin_hiz, 1);

        // clear command (R1, R10)
        cmd_clear = 1'b1; cyc(); cmd_clear = 1'b0;
        chk("R1 busy after clear", busy, 1);
        wr_en = 1'b1; wr_addr = '0; wr_data = 32'h000C_AFE1;
        len_we = 1'b1; len_in = 4'd5;
        cmd_step = 1'b1;
        cyc(); n = 1;
        wr_en = 1'b0; len_we = 1'b0; cmd_step = 1'b0;
        chk("R1 step ignored while busy", pin_hiz, 1);
        begin
            int m;
            wait_busy(m);
            n += m;
        end
        chk("R1 clear length", n, DEPTH);
        cmd_start = 1'b1; cyc(); cmd_start = 1'b0;
        sample_en = 1'b1; cyc();
        chk("R10 write during clear ignored", pin_data, 0);
        cyc(); sample_en = 1'b0;
        chk("R10 length write ignored", pin_hiz, 1);
        set_len(4'd15);
        cmd_start = 1'b1; cyc(); cmd_start = 1'b0;
        sample_en = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            cyc();
            chk("R1 zeroed word", pin_data, 0);
            chk("R1 zeroed word driven", pin_hiz, 0);
        end
        cyc(); sample_en = 1'b0;
        chk("R5 end after full depth", pin_hiz, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule